// File: doc/BRIEF.md
# Indexed Configuration Register Space

This block is the configuration front end of a multi-function peripheral device. A host on a byte-wide I/O bus writes a register number into an index port, then reads or writes a data port to reach that register. A strap input chooses which of two port pairs the block responds to. Most registers are global: a fixed identity byte, a chip configuration byte and a unit-select byte. A few registers are banked, with one copy per logical unit. The copy that the data port reaches is chosen by the unit-select value.

Each logical unit has an activation byte and a 16-bit runtime I/O base address. These drive the `unit_active` and `unit_base` outputs, which tell the rest of the device which units are live and where they decode. The general-purpose pin unit has three more banked registers. One is a pin selector that packs a port number and a bit number into one byte. The other two are a configuration byte and an event byte, stored separately for each pin and reached through the current selection. Software updates them by read-modify-write.

Bus reads go through a two-state machine. In `ST_IDLE` there is no response. A read strobe on either port captures the addressed value and moves to `ST_RESP`, which drives `io_rvalid` for one cycle. From `ST_RESP`, another read strobe stays in `ST_RESP` with the newly captured value. With no read strobe the machine returns to `ST_IDLE`.

Top module: `cfgsp_ctrl`

## Requirements
- R1: The index port is 0x002E when `strap_alt`=0 and 0x004E when `strap_alt`=1, and the data port is the index port plus one. Strobes at any other address change nothing and never raise `io_rvalid`.
- R2: A read strobe (`io_rd`=1, `io_wr`=0) on either port raises `io_rvalid` in the next cycle with the value sampled at the strobe edge in `io_rdata`. The index port returns the current index. `io_rdata` is 0x00 whenever `io_rvalid` is 0. A strobe with both `io_rd` and `io_wr` high performs only the write.
- R3: Index 0x20 always reads 0xE9, and writes to it are ignored.
- R4: Index 0x21 is an 8-bit read/write chip configuration byte that resets to 0x01.
- R5: Index 0x07 is an 8-bit read/write unit select that resets to 0xFF. Only the values 0x07 (pin unit, slot 0), 0x0D (slot 1) and 0x0E (slot 2) select a unit.
- R6: Index 0x30 is the activation byte of the selected unit, and `unit_active[slot]` is 1 exactly when that byte is nonzero. It resets to 0x01 for slot 0 and to 0x00 for the other slots.
- R7: Index 0x60 holds the high byte and index 0x61 the low byte of the selected unit's base address, which drives `unit_base[16*slot +: 16]`. It resets to `GPIO_BASE_RST` for slot 0 and to 0x0000 for the other slots.
- R8: A write to a banked register changes only the copy that belongs to the selected unit.
- R9: With the pin unit selected, index 0xF0 is the pin selector. Bits [5:4] are the port and bits [2:0] the bit, and bits 7, 6 and 3 are dropped. It reads back as {2'b00, port, 1'b0, bit} and resets to 0x00.
- R10: With the pin unit selected, index 0xF1 (configuration) and index 0xF2 (event) reach a separate byte for each of the 32 pins. The pin is port*8+bit from the selector. Both bytes reset to 0x00.
- R11: Indices that are not implemented read 0xFF and ignore writes. This includes 0x30, 0x60 and 0x61 when no unit is selected, and 0xF0 to 0xF2 when the pin unit is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_alt | input | 1 | Port-pair choice: 0 selects 0x2E/0x2F, 1 selects 0x4E/0x4F |
| io_addr | input | 16 | I/O bus address |
| io_wr | input | 1 | Write strobe, one cycle |
| io_rd | input | 1 | Read strobe, one cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read response, one cycle after a read strobe |
| unit_active | output | 3 | Activation flag per unit slot |
| unit_base | output | 48 | Runtime base address per unit slot, 16 bits each |

## Verification
The bench builds the block with `GPIO_BASE_RST` set to 0xA5C0. Because the two bytes of that value differ, the high and low base registers can be told apart at reset. The bench keeps the default four ports of eight pins, so all 32 per-pin byte pairs can be reached, including the top port, whose selector value would collide with a narrower port field. Its reference model runs every clock and covers both strap settings, so both port pairs and the silent addresses next to them are exercised in one run.

// File: rtl/cfgsp_pkg.sv
package cfgsp_pkg;

    localparam int N_UNITS   = 3;
    localparam int GPIO_SLOT = 0;

    localparam logic [15:0] PORT_PRI = 16'h002E;
    localparam logic [15:0] PORT_ALT = 16'h004E;

    localparam logic [7:0] IDX_UNIT_SEL = 8'h07;
    localparam logic [7:0] IDX_CHIP_ID  = 8'h20;
    localparam logic [7:0] IDX_CHIP_CFG = 8'h21;
    localparam logic [7:0] IDX_ACT      = 8'h30;
    localparam logic [7:0] IDX_BASE_HI  = 8'h60;
    localparam logic [7:0] IDX_BASE_LO  = 8'h61;
    localparam logic [7:0] IDX_PIN_SEL  = 8'hF0;
    localparam logic [7:0] IDX_PIN_CFG  = 8'hF1;
    localparam logic [7:0] IDX_PIN_EVT  = 8'hF2;

    localparam logic [7:0] CHIP_ID_VAL  = 8'hE9;
    localparam logic [7:0] CHIP_CFG_RST = 8'h01;
    localparam logic [7:0] NO_UNIT      = 8'hFF;

    typedef enum logic {ST_IDLE, ST_RESP} bus_state_e;

    function automatic logic [7:0] unit_id(input int slot);
        case (slot)
            0:       return 8'h07;
            1:       return 8'h0D;
            default: return 8'h0E;
        endcase
    endfunction

endpackage

// File: rtl/cfgsp_bus_fsm.sv
module cfgsp_bus_fsm
    import cfgsp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_alt,
    input  logic [15:0] io_addr,
    input  logic        io_wr,
    input  logic        io_rd,
    input  logic [7:0]  io_wdata,
    input  logic [7:0]  rd_value,
    output logic [7:0]  index,
    output logic        data_wr,
    output logic [7:0]  io_rdata,
    output logic        io_rvalid
);
    logic [15:0] idx_port;
    logic        hit_idx, hit_data, rd_req;
    bus_state_e  state_q, state_d;
    logic [7:0]  rdata_q, rdata_d;

    assign idx_port = strap_alt ? PORT_ALT : PORT_PRI;
    assign hit_idx  = (io_addr == idx_port);
    assign hit_data = (io_addr == idx_port + 16'd1);
    assign rd_req   = io_rd && !io_wr && (hit_idx || hit_data);
    assign data_wr  = io_wr && hit_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               index <= 8'h00;
        else if (io_wr && hit_idx) index <= io_wdata;
    end

    always_comb begin
        state_d = state_q;
        rdata_d = 8'h00;
        unique case (state_q)
            ST_IDLE: if (rd_req) state_d = ST_RESP;
            ST_RESP: state_d = rd_req ? ST_RESP : ST_IDLE;
        endcase
        if (rd_req) rdata_d = hit_idx ? index : rd_value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rdata_q <= 8'h00;
        end else begin
            state_q <= state_d;
            rdata_q <= rdata_d;
        end
    end

    always_comb begin
        io_rvalid = (state_q == ST_RESP);
        io_rdata  = (state_q == ST_RESP) ? rdata_q : 8'h00;
    end

    a_r2_resp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> io_rvalid);
    a_r1_silent_without_read: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !io_rvalid);
    a_r1_index_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && hit_idx) |=> $stable(index));

endmodule

// File: rtl/cfgsp_unit_bank.sv
module cfgsp_unit_bank
    import cfgsp_pkg::*;
#(
    parameter logic [7:0]  ACT_RST  = 8'h00,
    parameter logic [15:0] BASE_RST = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sel,
    input  logic [7:0]  index,
    input  logic        data_wr,
    input  logic [7:0]  wdata,
    output logic        active,
    output logic [15:0] base,
    output logic        rd_hit,
    output logic [7:0]  rd_val
);
    logic [7:0]  act_q;
    logic [15:0] base_q;
    logic        wr_en;

    assign wr_en = sel && data_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_q  <= ACT_RST;
            base_q <= BASE_RST;
        end else if (wr_en) begin
            if (index == IDX_ACT)     act_q        <= wdata;
            if (index == IDX_BASE_HI) base_q[15:8] <= wdata;
            if (index == IDX_BASE_LO) base_q[7:0]  <= wdata;
        end
    end

    always_comb begin
        rd_hit = sel && (index == IDX_ACT || index == IDX_BASE_HI || index == IDX_BASE_LO);
        case (index)
            IDX_ACT:     rd_val = act_q;
            IDX_BASE_HI: rd_val = base_q[15:8];
            IDX_BASE_LO: rd_val = base_q[7:0];
            default:     rd_val = 8'hFF;
        endcase
    end

    assign active = (act_q != 8'h00);
    assign base   = base_q;

    a_r6_act_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && index == IDX_ACT) |=> $stable(active));
    a_r8_base_holds_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable(base));

endmodule

// File: rtl/cfgsp_gpio_pins.sv
module cfgsp_gpio_pins
    import cfgsp_pkg::*;
#(
    parameter int         N_PORTS = 4,
    parameter int         N_BITS  = 8,
    parameter logic [7:0] CFG_RST = 8'h00,
    parameter logic [7:0] EVT_RST = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel,
    input  logic [7:0] index,
    input  logic       data_wr,
    input  logic [7:0] wdata,
    output logic       rd_hit,
    output logic [7:0] rd_val
);
    localparam int PORT_W = $clog2(N_PORTS);
    localparam int BIT_W  = $clog2(N_BITS);
    localparam int PIN_W  = PORT_W + BIT_W;
    localparam int N_PINS = N_PORTS * N_BITS;

    logic [PORT_W-1:0] port_q;
    logic [BIT_W-1:0]  bit_q;
    logic [PIN_W-1:0]  pin_idx;
    logic [7:0]        cfg_mem [N_PINS];
    logic [7:0]        evt_mem [N_PINS];
    logic [7:0]        sel_rb;
    logic              wr_en;

    assign wr_en   = sel && data_wr;
    assign pin_idx = {port_q, bit_q};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_q <= '0;
            bit_q  <= '0;
            for (int p = 0; p < N_PINS; p++) begin
                cfg_mem[p] <= CFG_RST;
                evt_mem[p] <= EVT_RST;
            end
        end else if (wr_en) begin
            if (index == IDX_PIN_SEL) begin
                port_q <= wdata[4 +: PORT_W];
                bit_q  <= wdata[BIT_W-1:0];
            end
            if (index == IDX_PIN_CFG) cfg_mem[pin_idx] <= wdata;
            if (index == IDX_PIN_EVT) evt_mem[pin_idx] <= wdata;
        end
    end

    always_comb begin
        sel_rb = 8'h00;
        sel_rb[4 +: PORT_W]  = port_q;
        sel_rb[BIT_W-1:0]    = bit_q;
        rd_hit = sel && (index == IDX_PIN_SEL || index == IDX_PIN_CFG || index == IDX_PIN_EVT);
        case (index)
            IDX_PIN_SEL: rd_val = sel_rb;
            IDX_PIN_CFG: rd_val = cfg_mem[pin_idx];
            IDX_PIN_EVT: rd_val = evt_mem[pin_idx];
            default:     rd_val = 8'hFF;
        endcase
    end

    a_r9_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && index == IDX_PIN_SEL) |=> $stable(pin_idx));

    for (genvar p = 0; p < N_PINS; p++) begin : g_pin_chk
        a_r10_only_selected_pin: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && index == IDX_PIN_CFG && pin_idx == PIN_W'(p)) |=> $stable(cfg_mem[p]));
    end

endmodule

// File: rtl/cfgsp_ctrl.sv
module cfgsp_ctrl
    import cfgsp_pkg::*;
#(
    parameter logic [15:0] GPIO_BASE_RST = 16'h0680,
    parameter int          PIN_PORTS     = 4,
    parameter int          PIN_BITS      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  strap_alt,
    input  logic [15:0]           io_addr,
    input  logic                  io_wr,
    input  logic                  io_rd,
    input  logic [7:0]            io_wdata,
    output logic [7:0]            io_rdata,
    output logic                  io_rvalid,
    output logic [N_UNITS-1:0]    unit_active,
    output logic [16*N_UNITS-1:0] unit_base
);
    logic [7:0]         index, rd_value, unit_sel_q, chip_cfg_q;
    logic               data_wr;
    logic [N_UNITS-1:0] u_hit;
    logic [7:0]         u_val [N_UNITS];
    logic               gp_hit;
    logic [7:0]         gp_val;

    cfgsp_bus_fsm u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .strap_alt (strap_alt),
        .io_addr   (io_addr),
        .io_wr     (io_wr),
        .io_rd     (io_rd),
        .io_wdata  (io_wdata),
        .rd_value  (rd_value),
        .index     (index),
        .data_wr   (data_wr),
        .io_rdata  (io_rdata),
        .io_rvalid (io_rvalid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unit_sel_q <= NO_UNIT;
            chip_cfg_q <= CHIP_CFG_RST;
        end else if (data_wr) begin
            if (index == IDX_UNIT_SEL) unit_sel_q <= io_wdata;
            if (index == IDX_CHIP_CFG) chip_cfg_q <= io_wdata;
        end
    end

    for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
        localparam logic [7:0] UID = unit_id(i);
        cfgsp_unit_bank #(
            .ACT_RST  ((i == GPIO_SLOT) ? 8'h01 : 8'h00),
            .BASE_RST ((i == GPIO_SLOT) ? GPIO_BASE_RST : 16'h0000)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .sel     (unit_sel_q == UID),
            .index   (index),
            .data_wr (data_wr),
            .wdata   (io_wdata),
            .active  (unit_active[i]),
            .base    (unit_base[16*i +: 16]),
            .rd_hit  (u_hit[i]),
            .rd_val  (u_val[i])
        );
    end

    cfgsp_gpio_pins #(
        .N_PORTS (PIN_PORTS),
        .N_BITS  (PIN_BITS)
    ) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (unit_sel_q == unit_id(GPIO_SLOT)),
        .index   (index),
        .data_wr (data_wr),
        .wdata   (io_wdata),
        .rd_hit  (gp_hit),
        .rd_val  (gp_val)
    );

    always_comb begin
        rd_value = 8'hFF;
        case (index)
            IDX_UNIT_SEL: rd_value = unit_sel_q;
            IDX_CHIP_ID:  rd_value = CHIP_ID_VAL;
            IDX_CHIP_CFG: rd_value = chip_cfg_q;
            default: begin
                if (gp_hit) rd_value = gp_val;
                for (int k = 0; k < N_UNITS; k++)
                    if (u_hit[k]) rd_value = u_val[k];
            end
        endcase
    end

    a_r8_single_source: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({gp_hit, u_hit}));
    a_r5_select_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && index == IDX_UNIT_SEL) |=> $stable(unit_sel_q));
    a_r4_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr && index == IDX_CHIP_CFG) |=> $stable(chip_cfg_q));

endmodule

// File: tb/cfgsp_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfgsp_ctrl_tb_top;

    localparam logic [15:0] BASE_RST = 16'hA5C0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap_alt = 1'b0;
    logic [15:0] io_addr = 16'h0000;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [7:0]  io_wdata = 8'h00;
    logic [7:0]  io_rdata;
    logic        io_rvalid;
    logic [2:0]  unit_active;
    logic [47:0] unit_base;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    cfgsp_ctrl #(.GPIO_BASE_RST(BASE_RST)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_alt(strap_alt), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_rvalid(io_rvalid), .unit_active(unit_active), .unit_base(unit_base)
    );

    // behavioural reference model
    int         uid [3] = '{7, 13, 14};
    logic [7:0] m_idx, m_sel, m_cfg, m_rdata;
    logic       m_rvalid;
    logic [7:0] m_act [3];
    logic [15:0] m_base [3];
    logic [7:0] m_pcfg [32];
    logic [7:0] m_pevt [32];
    int         m_port, m_bit;

    function automatic int slot_of();
        int s = -1;
        for (int k = 0; k < 3; k++) if (int'(m_sel) == uid[k]) s = k;
        return s;
    endfunction

    function automatic logic [7:0] mread(input logic [7:0] i);
        int s = slot_of();
        int pin = m_port * 8 + m_bit;
        case (i)
            8'h07: return m_sel;
            8'h20: return 8'hE9;
            8'h21: return m_cfg;
            8'h30: return (s >= 0) ? m_act[s] : 8'hFF;
            8'h60: return (s >= 0) ? m_base[s][15:8] : 8'hFF;
            8'h61: return (s >= 0) ? m_base[s][7:0] : 8'hFF;
            8'hF0: return (s == 0) ? 8'(m_port * 16 + m_bit) : 8'hFF;
            8'hF1: return (s == 0) ? m_pcfg[pin] : 8'hFF;
            8'hF2: return (s == 0) ? m_pevt[pin] : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx <= 8'h00; m_sel <= 8'hFF; m_cfg <= 8'h01;
            m_rvalid <= 1'b0; m_rdata <= 8'h00;
            m_port <= 0; m_bit <= 0;
            for (int k = 0; k < 3; k++) begin
                m_act[k]  <= (k == 0) ? 8'h01 : 8'h00;
                m_base[k] <= (k == 0) ? BASE_RST : 16'h0000;
            end
            for (int p = 0; p < 32; p++) begin
                m_pcfg[p] <= 8'h00; m_pevt[p] <= 8'h00;
            end
        end else begin
            logic [15:0] ip;
            int s;
            ip = strap_alt ? 16'h004E : 16'h002E;
            s  = slot_of();
            m_rvalid <= io_rd && !io_wr && (io_addr == ip || io_addr == ip + 1);
            m_rdata  <= (io_rd && !io_wr && io_addr == ip) ? m_idx :
                        (io_rd && !io_wr && io_addr == ip + 1) ? mread(m_idx) : 8'h00;
            if (io_wr && io_addr == ip) m_idx <= io_wdata;
            if (io_wr && io_addr == ip + 1) begin
                case (m_idx)
                    8'h07: m_sel <= io_wdata;
                    8'h21: m_cfg <= io_wdata;
                    8'h30: if (s >= 0) m_act[s] <= io_wdata;
                    8'h60: if (s >= 0) m_base[s][15:8] <= io_wdata;
                    8'h61: if (s >= 0) m_base[s][7:0] <= io_wdata;
                    8'hF0: if (s == 0) begin
                        m_port <= int'(io_wdata[5:4]);
                        m_bit  <= int'(io_wdata[2:0]);
                    end
                    8'hF1: if (s == 0) m_pcfg[m_port * 8 + m_bit] <= io_wdata;
                    8'hF2: if (s == 0) m_pevt[m_port * 8 + m_bit] <= io_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(io_rvalid === m_rvalid && io_rdata === m_rdata, "R2 model read response",
                {io_rvalid, io_rdata}, {m_rvalid, m_rdata});
            chk(unit_active === {m_act[2] != 0, m_act[1] != 0, m_act[0] != 0}, "R6 model active",
                unit_active, {m_act[2] != 0, m_act[1] != 0, m_act[0] != 0});
            chk(unit_base === {m_base[2], m_base[1], m_base[0]}, "R7 model base",
                unit_base, {m_base[2], m_base[1], m_base[0]});
        end
    end

    logic [15:0] ip = 16'h002E;

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [15:0] a, input logic [7:0] exp, input string tag);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        chk(io_rvalid === 1'b1 && io_rdata === exp, tag, {io_rvalid, io_rdata}, {1'b1, exp});
    endtask

    task automatic rd_none(input logic [15:0] a, input string tag);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        chk(io_rvalid === 1'b0, tag, io_rvalid, 1'b0);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] d);
        wr(ip, idx);
        wr(ip + 16'd1, d);
    endtask

    task automatic reg_chk(input logic [7:0] idx, input logic [7:0] exp, input string tag);
        wr(ip, idx);
        rd_chk(ip + 16'd1, exp, tag);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(unit_active === 3'b001, "R6 reset active", unit_active, 3'b001);
        chk(unit_base === {32'h0, BASE_RST}, "R7 reset base", unit_base, {32'h0, BASE_RST});
        chk(io_rvalid === 1'b0 && io_rdata === 8'h00, "R2 reset idle", {io_rvalid, io_rdata}, 9'h0);

        rd_chk(ip, 8'h00, "R2 index port read");
        reg_chk(8'h20, 8'hE9, "R3 id value");
        reg_wr(8'h20, 8'h55);
        reg_chk(8'h20, 8'hE9, "R3 id ignores write");
        rd_chk(ip, 8'h20, "R2 index reads back");

        reg_chk(8'h21, 8'h01, "R4 cfg reset");
        reg_wr(8'h21, 8'hA4);
        reg_chk(8'h21, 8'hA4, "R4 cfg write");

        reg_chk(8'h07, 8'hFF, "R5 select reset");
        reg_wr(8'h30, 8'h33);
        reg_chk(8'h30, 8'hFF, "R11 act without unit");
        chk(unit_active === 3'b001, "R11 write ignored", unit_active, 3'b001);
        reg_chk(8'hF1, 8'hFF, "R11 pin cfg without unit");

        reg_wr(8'h07, 8'h07);
        reg_chk(8'h07, 8'h07, "R5 select write");
        reg_chk(8'h30, 8'h01, "R6 gpio act");
        reg_chk(8'h60, 8'hA5, "R7 base high");
        reg_chk(8'h61, 8'hC0, "R7 base low");
        reg_wr(8'h60, 8'h12);
        reg_wr(8'h61, 8'h34);
        chk(unit_base[15:0] === 16'h1234, "R7 base output", unit_base[15:0], 16'h1234);

        reg_wr(8'h07, 8'h0D);
        reg_wr(8'h30, 8'h05);
        chk(unit_active === 3'b011, "R6 second unit active", unit_active, 3'b011);
        reg_wr(8'h61, 8'h9B);
        chk(unit_base === {16'h0, 16'h009B, 16'h1234}, "R8 banked base", unit_base,
            {16'h0, 16'h009B, 16'h1234});
        reg_chk(8'hF0, 8'hFF, "R11 pin select hidden");
        reg_wr(8'h07, 8'h0E);
        reg_chk(8'h30, 8'h00, "R8 third unit own act");
        reg_wr(8'h07, 8'h07);
        reg_wr(8'h30, 8'h00);
        chk(unit_active === 3'b010, "R6 deactivate gpio", unit_active, 3'b010);
        reg_chk(8'h61, 8'h34, "R8 gpio base kept");

        reg_chk(8'hF0, 8'h00, "R9 select reset");
        reg_wr(8'hF0, 8'hDA);
        reg_chk(8'hF0, 8'h12, "R9 select packing");
        reg_wr(8'hF1, 8'h3C);
        reg_wr(8'hF2, 8'h81);
        reg_wr(8'hF0, 8'h35);
        reg_chk(8'hF1, 8'h00, "R10 other pin cfg");
        reg_chk(8'hF2, 8'h00, "R10 other pin evt");
        reg_wr(8'hF2, 8'h7E);
        reg_wr(8'hF0, 8'h12);
        reg_chk(8'hF1, 8'h3C, "R10 pin cfg kept");
        reg_chk(8'hF2, 8'h81, "R10 pin evt kept");
        reg_wr(8'hF0, 8'h35);
        reg_chk(8'hF2, 8'h7E, "R10 top port evt");

        reg_wr(8'h99, 8'h11);
        reg_chk(8'h99, 8'hFF, "R11 unimplemented index");

        wr(16'h004E, 8'h21);
        rd_chk(ip, 8'h99, "R1 alternate port ignored");
        rd_none(16'h0050, "R1 other address silent");
        strap_alt = 1'b1;
        ip = 16'h004E;
        wr(ip, 8'h21);
        rd_chk(ip + 16'd1, 8'hA4, "R1 alternate data port");
        rd_none(16'h002F, "R1 primary silent under strap");

        io_addr = ip; io_wdata = 8'h07; io_rd = 1'b1; io_wr = 1'b1;
        @(negedge clk);
        io_rd = 1'b0; io_wr = 1'b0;
        chk(io_rvalid === 1'b0, "R2 write wins", io_rvalid, 1'b0);
        rd_chk(ip, 8'h07, "R2 combined strobe wrote index");

        repeat (4) @(negedge clk);
        done = 1;
        summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

endmodule